// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core between three operating modes: full-speed run, a light idle mode in which the core clock is gated while wake-up sources stay watched, and a deep sleep mode in which the core is powered down. Software or the core raises a request to idle or to sleep. A wake event, normally an interrupt line, brings the core back to run. Each move between modes is a timed transition with its own latency in clock cycles. Leaving sleep is by far the slowest move, and entering sleep takes longer than entering or leaving idle.

The block drives a core clock enable, a power-down control, a two-bit mode code and a busy flag that stays high for the whole of a transition. Requests that arrive while busy is high are dropped. Deep sleep is only entered from run. A sleep request made in idle first returns the core to run, then continues into sleep without stopping. Every cycle the block also adds a per-mode power weight to a saturating energy counter, so firmware can estimate what the core has consumed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in run with no transition pending: `mode` = 2'b00, `core_clk_en` = 1, `pwr_down` = 0, `busy` = 0 and `energy` = 0.
- R2: The `mode` code is 2'b00 for run, 2'b01 for idle and 2'b10 for sleep, and is never 2'b11. `core_clk_en` is high only when the core has settled in run. `pwr_down` is high only when it has settled in sleep. During a transition both are low and `mode` shows the mode being left.
- R3: An `idle_req` sampled in run keeps `busy` high for exactly `LAT_R2I` cycles, after which `mode` reads idle. A `wake_evt` sampled in idle keeps `busy` high for exactly `LAT_I2R` cycles, after which `mode` reads run.
- R4: A `sleep_req` sampled in run keeps `busy` high for exactly `LAT_R2S` cycles, after which the block is in sleep. When `sleep_req` and `idle_req` arrive together in run, sleep is taken.
- R5: A `wake_evt` sampled in sleep keeps `busy` high for exactly `LAT_S2R` cycles, after which the block is in run. In sleep, `idle_req` and `sleep_req` have no effect.
- R6: Any request or wake event sampled while `busy` is high is dropped. The transition ends on time at its original target, and nothing follows it.
- R7: A `sleep_req` sampled in idle (with no `wake_evt` in the same cycle) keeps `busy` high for `LAT_I2R + LAT_R2S` consecutive cycles. During the first `LAT_I2R` cycles `mode` reads idle, and after that it reads run. The block then settles in sleep. When `wake_evt` and `sleep_req` arrive together in idle, the block only returns to run.
- R8: A `wake_evt` sampled in run and an `idle_req` sampled in idle have no effect.
- R9: On every clock edge out of reset, `energy` grows by the weight of the state held in the cycle before: `W_RUN` in run, `W_IDLE` in idle, `W_SLEEP` in sleep. During a transition it grows by the larger weight of the two modes involved.
- R10: `energy` saturates at all ones and stays there instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| idle_req | input | 1 | Request to enter idle, sampled each cycle |
| sleep_req | input | 1 | Request to enter sleep, sampled each cycle |
| wake_evt | input | 1 | Wake event (interrupt), sampled each cycle |
| core_clk_en | output | 1 | Core clock enable, high in settled run |
| pwr_down | output | 1 | Core power-down control, high in settled sleep |
| mode | output | 2 | Current mode code (00 run, 01 idle, 10 sleep) |
| busy | output | 1 | High while a transition is in progress |
| energy | output | EW | Saturating energy-unit accumulator |

## Verification
The mode code, clock enable, power-down and busy outputs all decode straight from the state register. A wrong state therefore shows at the ports in the very cycle it is entered. A wrong latency count shows up as a busy window that ends one or more cycles early or late, and the directed tests count that window cycle by cycle for every transition. A wrong weight selection or a faulty add shows up in the next cycle as a wrong difference between two `energy` samples. The tests measure that difference in each settled mode, during a transition, and at the saturation limit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_R2I   = 3'd3,
    ST_I2R   = 3'd4,
    ST_R2S   = 3'd5,
    ST_S2R   = 3'd6
  } state_e;

  typedef enum logic [1:0] {
    GO_NONE  = 2'd0,
    GO_IDLE  = 2'd1,
    GO_SLEEP = 2'd2,
    GO_WAKE  = 2'd3
  } go_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pmc_arbiter.sv
module pmc_arbiter
  import pmc_pkg::*;
(
  input  state_e state,
  input  logic   idle_req,
  input  logic   sleep_req,
  input  logic   wake_evt,
  output go_e    go,
  output logic   defer_sleep
);

  // Only settled modes accept requests; transitions drop everything.
  always_comb begin
    go          = GO_NONE;
    defer_sleep = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (sleep_req)     go = GO_SLEEP;
        else if (idle_req) go = GO_IDLE;
      end
      ST_IDLE: begin
        if (wake_evt) begin
          go = GO_WAKE;
        end else if (sleep_req) begin
          go          = GO_WAKE;
          defer_sleep = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_evt) go = GO_WAKE;
      end
      default: go = GO_NONE;
    endcase
  end

endmodule

// File: rtl/pmc_latency_timer.sv
module pmc_latency_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pmc_energy_acc.sv
module pmc_energy_acc #(
  parameter int unsigned EW = 32,
  parameter int unsigned WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] weight,
  output logic [EW-1:0] energy
);

  logic [EW-1:0] acc_q;
  logic [EW-1:0] acc_d;
  logic [EW:0]   sum;
  logic          acc_en;

  always_comb begin
    sum    = {1'b0, acc_q} + (EW+1)'(weight);
    acc_en = (acc_q != {EW{1'b1}});
    if (sum[EW]) acc_d = {EW{1'b1}};
    else         acc_d = sum[EW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign energy = acc_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned LAT_R2I = 500,
  parameter int unsigned LAT_I2R = 500,
  parameter int unsigned LAT_R2S = 4500,
  parameter int unsigned LAT_S2R = 8000000,
  parameter int unsigned W_RUN   = 2500,
  parameter int unsigned W_IDLE  = 313,
  parameter int unsigned W_SLEEP = 1,
  parameter int unsigned EW      = 32,
  parameter int unsigned WW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req,
  input  logic          sleep_req,
  input  logic          wake_evt,
  output logic          core_clk_en,
  output logic          pwr_down,
  output logic [1:0]    mode,
  output logic          busy,
  output logic [EW-1:0] energy
);

  localparam int unsigned LAT_MAX = max_u(max_u(LAT_R2I, LAT_I2R), max_u(LAT_R2S, LAT_S2R));
  localparam int unsigned CW      = $clog2(LAT_MAX) + 1;
  localparam int unsigned W_T_RI  = max_u(W_RUN, W_IDLE);
  localparam int unsigned W_T_RS  = max_u(W_RUN, W_SLEEP);

  state_e        state_q, state_d;
  logic          pend_q, pend_d;
  go_e           go;
  logic          defer_sleep;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_done;
  logic [WW-1:0] weight;
  mode_e         mode_dec;

  pmc_arbiter u_arb (
    .state       (state_q),
    .idle_req    (idle_req),
    .sleep_req   (sleep_req),
    .wake_evt    (wake_evt),
    .go          (go),
    .defer_sleep (defer_sleep)
  );

  pmc_latency_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  // Next-state logic: a transition lasts LAT cycles, loaded as LAT-1.
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_RUN: begin
        if (go == GO_SLEEP) begin
          state_d = ST_R2S;
          t_load  = 1'b1;
          t_val   = CW'(LAT_R2S - 1);
        end else if (go == GO_IDLE) begin
          state_d = ST_R2I;
          t_load  = 1'b1;
          t_val   = CW'(LAT_R2I - 1);
        end
      end
      ST_IDLE: begin
        if (go == GO_WAKE) begin
          state_d = ST_I2R;
          pend_d  = defer_sleep;
          t_load  = 1'b1;
          t_val   = CW'(LAT_I2R - 1);
        end
      end
      ST_SLEEP: begin
        if (go == GO_WAKE) begin
          state_d = ST_S2R;
          t_load  = 1'b1;
          t_val   = CW'(LAT_S2R - 1);
        end
      end
      ST_R2I: if (t_done) state_d = ST_IDLE;
      ST_I2R: begin
        if (t_done) begin
          if (pend_q) begin
            state_d = ST_R2S;
            pend_d  = 1'b0;
            t_load  = 1'b1;
            t_val   = CW'(LAT_R2S - 1);
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_R2S: if (t_done) state_d = ST_SLEEP;
      ST_S2R: if (t_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  // Output decode from the state register.
  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_I2R:  mode_dec = MODE_IDLE;
      ST_SLEEP, ST_S2R: mode_dec = MODE_SLEEP;
      default:          mode_dec = MODE_RUN;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:         weight = WW'(W_RUN);
      ST_IDLE:        weight = WW'(W_IDLE);
      ST_SLEEP:       weight = WW'(W_SLEEP);
      ST_R2I, ST_I2R: weight = WW'(W_T_RI);
      default:        weight = WW'(W_T_RS);
    endcase
  end

  pmc_energy_acc #(.EW(EW), .WW(WW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .weight (weight),
    .energy (energy)
  );

  assign mode        = mode_dec;
  assign core_clk_en = (state_q == ST_RUN);
  assign pwr_down    = (state_q == ST_SLEEP);
  assign busy        = (state_q != ST_RUN) && (state_q != ST_IDLE) && (state_q != ST_SLEEP);

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int unsigned EW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_req,
  input logic          sleep_req,
  input logic          wake_evt,
  input logic          core_clk_en,
  input logic          pwr_down,
  input logic [1:0]    mode,
  input logic          busy,
  input logic [EW-1:0] energy
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11); // R2

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_clk_en && pwr_down)); // R2

  AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!core_clk_en && !pwr_down)); // R2

  AST_ENTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && idle_req && !sleep_req) |=> (busy && mode == MODE_RUN)); // R3

  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && sleep_req) |=> (busy && mode == MODE_RUN)); // R4

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !wake_evt) |=> pwr_down); // R5

  AST_NO_IDLE_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |=> (mode != MODE_SLEEP)); // R7

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !idle_req && !sleep_req) |=> core_clk_en); // R8

  AST_ENERGY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (energy > $past(energy) || energy == {EW{1'b1}})); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (energy == {EW{1'b1}}) |=> (energy == {EW{1'b1}})); // R10

endmodule

bind pwr_mode_ctrl pmc_checker #(.EW(EW)) u_pmc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle_req    (idle_req),
  .sleep_req   (sleep_req),
  .wake_evt    (wake_evt),
  .core_clk_en (core_clk_en),
  .pwr_down    (pwr_down),
  .mode        (mode),
  .busy        (busy),
  .energy      (energy)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

  localparam int unsigned L_RI = 3;
  localparam int unsigned L_IR = 3;
  localparam int unsigned L_RS = 5;
  localparam int unsigned L_SR = 12;
  localparam int unsigned WR   = 40;
  localparam int unsigned WI   = 5;
  localparam int unsigned WS   = 1;
  localparam int unsigned EWB  = 12;
  localparam logic [1:0] M_RUN = 2'd0, M_IDLE = 2'd1, M_SLEEP = 2'd2;

  logic clk = 1'b0;
  logic rst_n;
  logic idle_req, sleep_req, wake_evt;
  logic core_clk_en, pwr_down, busy;
  logic [1:0] mode;
  logic [EWB-1:0] energy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(
    .LAT_R2I(L_RI), .LAT_I2R(L_IR), .LAT_R2S(L_RS), .LAT_S2R(L_SR),
    .W_RUN(WR), .W_IDLE(WI), .W_SLEEP(WS), .EW(EWB), .WW(16)
  ) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .core_clk_en(core_clk_en), .pwr_down(pwr_down),
    .mode(mode), .busy(busy), .energy(energy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    idle_req = 0; sleep_req = 0; wake_evt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // Drive for one cycle; returns at the first negedge after the capturing edge.
  task automatic pulse(input bit i, input bit s, input bit w);
    idle_req = i; sleep_req = s; wake_evt = w;
    @(negedge clk);
    idle_req = 0; sleep_req = 0; wake_evt = 0;
  endtask

  // Called right after pulse: checks a busy window of lat cycles, then arrival.
  task automatic window(input int lat, input logic [1:0] src, input logic [1:0] dst,
                        input string req);
    int bad = 0;
    for (int k = 0; k < lat; k++) begin
      if (k > 0) @(negedge clk);
      if (!busy || mode != src || core_clk_en || pwr_down) bad++;
    end
    chk(bad == 0, req, "busy window cycles wrong", bad, 0);
    @(negedge clk);
    chk(!busy && mode == dst, req, "mode after window", {busy, mode}, {1'b0, dst});
  endtask

  task automatic t_reset();
    idle_req = 0; sleep_req = 0; wake_evt = 0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk(mode == M_RUN && core_clk_en && !pwr_down && !busy, "R1", "reset outputs",
        {mode, core_clk_en, pwr_down, busy}, {M_RUN, 3'b100});
    chk(energy == 0, "R1", "reset energy", energy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(energy == WR, "R9", "first run cycle energy", energy, WR);
    @(negedge clk);
    chk(energy == 2*WR, "R9", "second run cycle energy", energy, 2*WR);
  endtask

  task automatic t_idle_cycle();
    longint e0;
    do_reset();
    pulse(1, 0, 0);
    window(L_RI, M_RUN, M_IDLE, "R3");
    chk(!core_clk_en && !pwr_down, "R2", "idle enables", {core_clk_en, pwr_down}, 0);
    e0 = energy;
    repeat (4) @(negedge clk);
    chk(energy == e0 + 4*WI, "R9", "idle weight", energy, e0 + 4*WI);
    pulse(1, 0, 0);
    chk(!busy && mode == M_IDLE, "R8", "idle_req in idle", {busy, mode}, M_IDLE);
    pulse(0, 0, 1);
    e0 = energy;
    @(negedge clk);
    chk(energy == e0 + WR, "R9", "transition weight", energy, e0 + WR);
    repeat (L_IR - 2) @(negedge clk);
    @(negedge clk);
    chk(!busy && mode == M_RUN && core_clk_en, "R3", "back in run after wake",
        {busy, mode, core_clk_en}, {1'b0, M_RUN, 1'b1});
  endtask

  task automatic t_sleep_cycle();
    longint e0;
    do_reset();
    pulse(1, 1, 0);
    window(L_RS, M_RUN, M_SLEEP, "R4");
    chk(pwr_down && !core_clk_en, "R2", "sleep enables", {pwr_down, core_clk_en}, 2);
    e0 = energy;
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    pulse(1, 1, 0);
    @(negedge clk);
    chk(!busy && mode == M_SLEEP && pwr_down, "R5", "requests in sleep ignored",
        {busy, mode}, M_SLEEP);
    chk(energy == e0 + 4*WS, "R9", "sleep weight", energy, e0 + 4*WS);
    pulse(0, 0, 1);
    window(L_SR, M_SLEEP, M_RUN, "R5");
    chk(core_clk_en && !pwr_down, "R2", "run enables after wake", {core_clk_en, pwr_down}, 2);
  endtask

  task automatic t_busy_ignore();
    int bad = 0;
    do_reset();
    pulse(1, 0, 0);
    if (!busy) bad++;
    idle_req = 1; sleep_req = 1; wake_evt = 1;
    @(negedge clk);
    idle_req = 0; sleep_req = 0; wake_evt = 0;
    if (!busy || mode != M_RUN) bad++;
    @(negedge clk);
    if (!busy || mode != M_RUN) bad++;
    chk(bad == 0, "R6", "window kept while busy", bad, 0);
    @(negedge clk);
    chk(!busy && mode == M_IDLE, "R6", "original target reached", {busy, mode}, M_IDLE);
    repeat (3) @(negedge clk);
    chk(!busy && mode == M_IDLE, "R6", "no follow-up transition", {busy, mode}, M_IDLE);
  endtask

  task automatic t_idle_to_sleep();
    int bad = 0;
    do_reset();
    pulse(1, 0, 0);
    window(L_RI, M_RUN, M_IDLE, "R7");
    pulse(0, 1, 0);
    for (int k = 0; k < int'(L_IR + L_RS); k++) begin
      if (k > 0) @(negedge clk);
      if (!busy) bad++;
      if (k < int'(L_IR) && mode != M_IDLE) bad++;
      if (k >= int'(L_IR) && mode != M_RUN) bad++;
    end
    chk(bad == 0, "R7", "idle-run-sleep chained window", bad, 0);
    @(negedge clk);
    chk(!busy && mode == M_SLEEP && pwr_down, "R7", "settled in sleep", {busy, mode}, M_SLEEP);

    do_reset();
    pulse(1, 0, 0);
    window(L_RI, M_RUN, M_IDLE, "R7");
    pulse(0, 1, 1);
    window(L_IR, M_IDLE, M_RUN, "R7");
    repeat (3) @(negedge clk);
    chk(!busy && mode == M_RUN, "R7", "wake beats sleep in idle", {busy, mode}, M_RUN);
  endtask

  task automatic t_run_wake();
    do_reset();
    pulse(0, 0, 1);
    chk(!busy && mode == M_RUN && core_clk_en, "R8", "wake in run ignored",
        {busy, mode}, M_RUN);
  endtask

  task automatic t_saturate();
    do_reset();
    repeat (120) @(negedge clk);
    chk(energy == (1 << EWB) - 1, "R10", "saturated", energy, (1 << EWB) - 1);
    repeat (2) @(negedge clk);
    chk(energy == (1 << EWB) - 1, "R10", "holds at max", energy, (1 << EWB) - 1);
  endtask

  initial begin
    t_reset();
    t_idle_cycle();
    t_sleep_cycle();
    t_busy_ignore();
    t_idle_to_sleep();
    t_run_wake();
    t_saturate();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule